// File: doc/BRIEF.md
# Logical-to-Physical Pin Crossbar

This block connects a small group of logical pins, shared by several internal peripherals, to a large field of physical pads. A write-only configuration port holds one map entry per logical pin. Each entry has a valid flag and a pad index. A selector register names the peripheral that currently owns the logical pins. Only that peripheral can drive pads, through the pads its logical pins are mapped to. Every peripheral sees the same logical input bus, which carries the pad values returned through the map.

Each peripheral presents one output value and one output enable per logical pin. These arrive on flat buses, with the slot number equal to the peripheral's selector code. Outside this block, each peripheral gives the low logical pins a fixed role. Serial-peripheral master and slave use pins 0 to 3 as data out, data in, clock and select. The UART uses them as transmit, receive, clear-to-send and request-to-send. I2C uses pins 0 and 1 as data and clock. A control register clears the map, or issues a peripheral reset that leaves the map intact.

Top module: `pad_xbar`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every map entry is unmapped and the selector is 0. Every pad has output enable 0 and output value 0, `lpin_in_o` is 0 and `periph_rst_o` is 0.
- R2: A write to address L (0 to 15) sets map entry L. Data bit 7 is the valid flag and bits 6:0 are the pad index (0 to 127). Writing valid 0 unmaps the logical pin.
- R3: A pad that a valid entry for logical pin L references takes enable and value from slot `sel*16+L` of `periph_oe_i`/`periph_out_i`. The pad outputs are registered and follow an input change after one clock edge.
- R4: A write to address 16 sets the selector from data bits 2:0. Code 1 is GPIO, 2 is SPI master, 4 is UART, 5 is I2C and 6 is SPI slave. Codes 0, 3 and 7 select no peripheral, so all pad enables are 0.
- R5: The output and enable bits of peripheral slots other than the selected one have no effect on any pad.
- R6: `lpin_in_o[L]` equals `pad_in_i` at the pad mapped to L, registered one edge later. The value does not depend on the selector.
- R7: An unmapped logical pin reads as 0 on `lpin_in_o` and drives no pad.
- R8: When several valid entries reference one pad, the lowest-numbered logical pin owns it, even when that pin's enable is 0.
- R9: A pad that no valid entry references has enable 0. A pad value is 0 whenever its enable is 0.
- R10: A write to address 17 with data bit 0 set unmaps all entries. The selector is kept.
- R11: A write to address 17 with data bit 1 set pulses `periph_rst_o` high for one cycle and returns the selector to 0. The map entries are kept.
- R12: Writes to addresses 18 to 31 change neither map nor selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| periph_out_i | input | 128 | Per-peripheral, per-logical-pin output values, slot = code*16+pin |
| periph_oe_i | input | 128 | Per-peripheral, per-logical-pin output enables, same layout |
| lpin_in_o | output | 16 | Logical pin input values seen by all peripherals |
| periph_rst_o | output | 1 | One-cycle peripheral reset pulse |
| pad_in_i | input | 128 | Pad input values |
| pad_out_o | output | 128 | Pad output values |
| pad_oe_o | output | 128 | Pad output enables |

## Verification
On every cycle, the assertions check the invariants that do not depend on the map contents. A quiet selector code never leaves a pad enabled. A pad value never appears without its enable. The number of enabled pads never exceeds the number of valid entries, and unmapped logical pins read 0. The clear, peripheral-reset and unused-address writes have their stated effect on the map and selector. Only the bench scenarios show that values reach the right pad and return to the right logical pin, that the lower pin wins a shared pad, that other slots are ignored, and that the outputs have a one-edge latency.

// File: rtl/pad_xbar_pkg.sv
package pad_xbar_pkg;

    localparam int unsigned SEL_W              = 3;
    localparam int unsigned DEF_PAD_COUNT      = 128;
    localparam int unsigned DEF_LPINS_PER_BANK = 8;
    localparam int unsigned DEF_BANKS          = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE  = 3'd0,
        SEL_GPIO  = 3'd1,
        SEL_SPI_M = 3'd2,
        SEL_UART  = 3'd4,
        SEL_I2C   = 3'd5,
        SEL_SPI_S = 3'd6
    } sel_code_e;

    // True for codes that name a real peripheral slot.
    function automatic logic sel_code_ok(input logic [SEL_W-1:0] code);
        logic ok;
        case (code)
            SEL_GPIO, SEL_SPI_M, SEL_UART, SEL_I2C, SEL_SPI_S: ok = 1'b1;
            default:                                           ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pad_xbar_cfg.sv
module pad_xbar_cfg
    import pad_xbar_pkg::*;
#(
    parameter int unsigned LPIN_COUNT = 16,
    parameter int unsigned PAD_IDX_W  = 7,
    parameter int unsigned ADDR_W     = 5,
    localparam int unsigned DATA_W    = PAD_IDX_W + 1,
    localparam int unsigned LIDX_W    = $clog2(LPIN_COUNT)
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [LPIN_COUNT-1:0]           map_vld_o,
    output logic [LPIN_COUNT*PAD_IDX_W-1:0] map_idx_o,
    output logic [SEL_W-1:0]                sel_o,
    output logic                            periph_rst_o
);

    localparam logic [ADDR_W-1:0] SEL_ADDR  = ADDR_W'(LPIN_COUNT);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(LPIN_COUNT + 1);

    typedef struct packed {
        logic [LPIN_COUNT-1:0]                vld;
        logic [LPIN_COUNT-1:0][PAD_IDX_W-1:0] idx;
        logic [SEL_W-1:0]                     sel;
        logic                                 prst;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prst = 1'b0;
        if (we_i) begin
            if (addr_i < SEL_ADDR) begin
                state_d.vld[addr_i[LIDX_W-1:0]] = wdata_i[PAD_IDX_W];
                state_d.idx[addr_i[LIDX_W-1:0]] = wdata_i[PAD_IDX_W-1:0];
            end else if (addr_i == SEL_ADDR) begin
                state_d.sel = wdata_i[SEL_W-1:0];
            end else if (addr_i == CTRL_ADDR) begin
                if (wdata_i[0]) begin
                    state_d.vld = '0;
                    state_d.idx = '0;
                end
                if (wdata_i[1]) begin
                    state_d.prst = 1'b1;
                    state_d.sel  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign map_vld_o    = state_q.vld;
    assign map_idx_o    = state_q.idx;
    assign sel_o        = state_q.sel;
    assign periph_rst_o = state_q.prst;

endmodule

// File: rtl/pad_xbar_drive.sv
module pad_xbar_drive
    import pad_xbar_pkg::*;
#(
    parameter int unsigned PAD_COUNT  = 128,
    parameter int unsigned LPIN_COUNT = 16,
    parameter int unsigned PAD_IDX_W  = 7,
    localparam int unsigned NUM_SLOTS = 1 << SEL_W,
    localparam int unsigned LIDX_W    = $clog2(LPIN_COUNT)
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [LPIN_COUNT-1:0]           map_vld_i,
    input  logic [LPIN_COUNT*PAD_IDX_W-1:0] map_idx_i,
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [NUM_SLOTS*LPIN_COUNT-1:0] periph_out_i,
    input  logic [NUM_SLOTS*LPIN_COUNT-1:0] periph_oe_i,
    output logic [PAD_COUNT-1:0]            pad_out_o,
    output logic [PAD_COUNT-1:0]            pad_oe_o
);

    typedef struct packed {
        logic [PAD_COUNT-1:0] val;
        logic [PAD_COUNT-1:0] oe;
    } drive_state_t;

    drive_state_t state_d, state_q;

    logic [LPIN_COUNT-1:0] own_out;
    logic [LPIN_COUNT-1:0] own_oe;
    logic                  own_ok;

    // Slice of the selected peripheral only.
    assign own_out = periph_out_i[int'(sel_i)*LPIN_COUNT +: LPIN_COUNT];
    assign own_oe  = periph_oe_i[int'(sel_i)*LPIN_COUNT +: LPIN_COUNT];
    assign own_ok  = sel_code_ok(sel_i);

    always_comb begin
        state_d = '0;
        for (int p = 0; p < PAD_COUNT; p++) begin
            logic              hit;
            logic [LIDX_W-1:0] src;
            hit = 1'b0;
            src = '0;
            // Scan downward so the lowest matching logical pin is kept.
            for (int l = LPIN_COUNT - 1; l >= 0; l--) begin
                if (map_vld_i[l] &&
                    map_idx_i[l*PAD_IDX_W +: PAD_IDX_W] == PAD_IDX_W'(p)) begin
                    hit = 1'b1;
                    src = LIDX_W'(l);
                end
            end
            state_d.oe[p]  = hit && own_ok && own_oe[src];
            state_d.val[p] = hit && own_ok && own_oe[src] && own_out[src];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pad_out_o = state_q.val;
    assign pad_oe_o  = state_q.oe;

endmodule

// File: rtl/pad_xbar_sense.sv
module pad_xbar_sense #(
    parameter int unsigned PAD_COUNT  = 128,
    parameter int unsigned LPIN_COUNT = 16,
    parameter int unsigned PAD_IDX_W  = 7
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [LPIN_COUNT-1:0]           map_vld_i,
    input  logic [LPIN_COUNT*PAD_IDX_W-1:0] map_idx_i,
    input  logic [PAD_COUNT-1:0]            pad_in_i,
    output logic [LPIN_COUNT-1:0]           lpin_in_o
);

    typedef struct packed {
        logic [LPIN_COUNT-1:0] lin;
    } sense_state_t;

    sense_state_t state_d, state_q;

    always_comb begin
        state_d = '0;
        for (int l = 0; l < LPIN_COUNT; l++) begin
            if (map_vld_i[l]) begin
                state_d.lin[l] = pad_in_i[map_idx_i[l*PAD_IDX_W +: PAD_IDX_W]];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lpin_in_o = state_q.lin;

endmodule

// File: rtl/pad_xbar.sv
module pad_xbar
    import pad_xbar_pkg::*;
#(
    parameter int unsigned PAD_COUNT      = DEF_PAD_COUNT,
    parameter int unsigned LPINS_PER_BANK = DEF_LPINS_PER_BANK,
    parameter int unsigned BANKS          = DEF_BANKS,
    localparam int unsigned LPIN_COUNT    = LPINS_PER_BANK * BANKS,
    localparam int unsigned PAD_IDX_W     = $clog2(PAD_COUNT),
    localparam int unsigned DATA_W        = PAD_IDX_W + 1,
    localparam int unsigned ADDR_W        = $clog2(LPIN_COUNT + 2),
    localparam int unsigned NUM_SLOTS     = 1 << SEL_W
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            cfg_we_i,
    input  logic [ADDR_W-1:0]               cfg_addr_i,
    input  logic [DATA_W-1:0]               cfg_wdata_i,
    input  logic [NUM_SLOTS*LPIN_COUNT-1:0] periph_out_i,
    input  logic [NUM_SLOTS*LPIN_COUNT-1:0] periph_oe_i,
    output logic [LPIN_COUNT-1:0]           lpin_in_o,
    output logic                            periph_rst_o,
    input  logic [PAD_COUNT-1:0]            pad_in_i,
    output logic [PAD_COUNT-1:0]            pad_out_o,
    output logic [PAD_COUNT-1:0]            pad_oe_o
);

    logic [LPIN_COUNT-1:0]           map_vld;
    logic [LPIN_COUNT*PAD_IDX_W-1:0] map_idx;
    logic [SEL_W-1:0]                sel_code;

    pad_xbar_cfg #(
        .LPIN_COUNT (LPIN_COUNT),
        .PAD_IDX_W  (PAD_IDX_W),
        .ADDR_W     (ADDR_W)
    ) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (cfg_we_i),
        .addr_i       (cfg_addr_i),
        .wdata_i      (cfg_wdata_i),
        .map_vld_o    (map_vld),
        .map_idx_o    (map_idx),
        .sel_o        (sel_code),
        .periph_rst_o (periph_rst_o)
    );

    pad_xbar_drive #(
        .PAD_COUNT  (PAD_COUNT),
        .LPIN_COUNT (LPIN_COUNT),
        .PAD_IDX_W  (PAD_IDX_W)
    ) u_drive (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .map_vld_i    (map_vld),
        .map_idx_i    (map_idx),
        .sel_i        (sel_code),
        .periph_out_i (periph_out_i),
        .periph_oe_i  (periph_oe_i),
        .pad_out_o    (pad_out_o),
        .pad_oe_o     (pad_oe_o)
    );

    pad_xbar_sense #(
        .PAD_COUNT  (PAD_COUNT),
        .LPIN_COUNT (LPIN_COUNT),
        .PAD_IDX_W  (PAD_IDX_W)
    ) u_sense (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .map_vld_i (map_vld),
        .map_idx_i (map_idx),
        .pad_in_i  (pad_in_i),
        .lpin_in_o (lpin_in_o)
    );

endmodule

// File: rtl/pad_xbar_chk.sv
module pad_xbar_chk
    import pad_xbar_pkg::*;
#(
    parameter int unsigned PAD_COUNT  = 128,
    parameter int unsigned LPIN_COUNT = 16,
    parameter int unsigned ADDR_W     = 5
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  cfg_we_i,
    input logic [ADDR_W-1:0]     cfg_addr_i,
    input logic [1:0]            ctrl_bits,
    input logic [LPIN_COUNT-1:0] map_vld,
    input logic [SEL_W-1:0]      sel_code,
    input logic                  periph_rst_o,
    input logic [PAD_COUNT-1:0]  pad_out_o,
    input logic [PAD_COUNT-1:0]  pad_oe_o,
    input logic [LPIN_COUNT-1:0] lpin_in_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(LPIN_COUNT + 1);

    // R4: a code without a peripheral leaves every pad undriven next cycle
    p_quiet_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_code_ok(sel_code) |=> (pad_oe_o == '0));

    // R9: a value appears on a pad only together with its enable
    p_value_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pad_out_o & ~pad_oe_o) == '0));

    // R9: enabled pads never outnumber the valid map entries behind them
    p_enable_bounded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($countones(pad_oe_o) <= $countones($past(map_vld))));

    // R7: an unmapped logical pin reads 0
    p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((lpin_in_o & ~$past(map_vld)) == '0));

    // R10: the clear command empties the map
    p_clear_map_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == CTRL_ADDR && ctrl_bits[0]) |=> (map_vld == '0));

    // R11: peripheral reset pulses and drops the selector but keeps the map
    p_prst_keeps_map_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == CTRL_ADDR && ctrl_bits == 2'b10) |=>
        (periph_rst_o && sel_code == '0 && map_vld == $past(map_vld)));

    // R11: the pulse only follows a peripheral reset command
    p_prst_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        periph_rst_o |-> $past(cfg_we_i && cfg_addr_i == CTRL_ADDR && ctrl_bits[1]));

    // R12: unused addresses leave map and selector alone
    p_unused_addr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i > CTRL_ADDR) |=>
        (map_vld == $past(map_vld) && sel_code == $past(sel_code)));

endmodule

bind pad_xbar pad_xbar_chk #(
    .PAD_COUNT  (PAD_COUNT),
    .LPIN_COUNT (LPIN_COUNT),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .ctrl_bits    (cfg_wdata_i[1:0]),
    .map_vld      (map_vld),
    .sel_code     (sel_code),
    .periph_rst_o (periph_rst_o),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o),
    .lpin_in_o    (lpin_in_o)
);

// File: tb/pad_xbar_tb.sv
module pad_xbar_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 128;
    localparam int NL = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [4:0]      cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [8*NL-1:0] p_out = '0;
    logic [8*NL-1:0] p_oe = '0;
    logic [NL-1:0]   lpin_in;
    logic            prst;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out;
    logic [NP-1:0]   pad_oe;

    int checks = 0;
    int fails  = 0;

    // Bench model of the configuration
    logic       mv [NL];
    logic [6:0] mp [NL];
    logic [2:0] msel;

    logic [NP-1:0] e_oe, e_out;
    logic [NL-1:0] e_lin;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_xbar u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .periph_out_i (p_out),
        .periph_oe_i  (p_oe),
        .lpin_in_o    (lpin_in),
        .periph_rst_o (prst),
        .pad_in_i     (pad_in),
        .pad_out_o    (pad_out),
        .pad_oe_o     (pad_oe)
    );

    function automatic logic code_ok(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd5) || (c == 3'd6);
    endfunction

    task automatic model_clear();
        for (int l = 0; l < NL; l++) begin
            mv[l] = 1'b0;
            mp[l] = '0;
        end
        msel = '0;
    endtask

    task automatic compute_exp();
        logic [NL-1:0] so, se;
        so = p_out[int'(msel)*NL +: NL];
        se = p_oe[int'(msel)*NL +: NL];
        e_oe  = '0;
        e_out = '0;
        for (int p = 0; p < NP; p++) begin
            int hit;
            hit = -1;
            for (int l = 0; l < NL; l++) begin
                if (hit < 0 && mv[l] && mp[l] == 7'(p)) hit = l;
            end
            if (hit >= 0 && code_ok(msel) && se[hit]) begin
                e_oe[p]  = 1'b1;
                e_out[p] = so[hit];
            end
        end
        for (int l = 0; l < NL; l++) e_lin[l] = mv[l] ? pad_in[mp[l]] : 1'b0;
    endtask

    task automatic check_vec(input string req, input string what,
                             input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        compute_exp();
        check_vec(req, "pad_oe", pad_oe, e_oe);
        check_vec(req, "pad_out", pad_out, e_out);
        check_vec(req, "lpin_in", {{(NP-NL){1'b0}}, lpin_in}, {{(NP-NL){1'b0}}, e_lin});
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drives one write and updates the model from the requirements.
    task automatic cfg_write(input logic [4:0] a, input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 5'd16) begin
            mv[a[3:0]] = d[7];
            mp[a[3:0]] = d[6:0];
        end else if (a == 5'd16) begin
            msel = d[2:0];
        end else if (a == 5'd17) begin
            if (d[0]) for (int l = 0; l < NL; l++) mv[l] = 1'b0;
            if (d[1]) msel = '0;
        end
    endtask

    task automatic map(input int l, input int pad);
        cfg_write(5'(l), {1'b1, 7'(pad)});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [NP-1:0] old_oe, old_out;
        void'($urandom(32'd20240611));
        model_clear();
        p_out  = '1;
        p_oe   = '1;
        pad_in = '1;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check_vec("R1", "pad_oe in reset", pad_oe, '0);
        rst_n = 1'b1;
        settle();
        // R1, R7: reset state, nothing mapped so nothing driven or read
        check_all("R1");
        check_vec("R1", "periph_rst", {127'd0, prst}, '0);

        // R2, R3: GPIO selected, boundary pad indexes
        cfg_write(5'd16, 8'd1);
        map(0, 5);
        map(3, 127);
        map(7, 0);
        map(12, 64);
        p_out = '0;
        p_oe  = '0;
        p_out[1*NL +: NL] = 16'h1089;
        p_oe[1*NL +: NL]  = 16'h1089;
        settle();
        check_all("R2");

        // R3: one-edge latency on a peripheral change
        compute_exp();
        old_oe  = e_oe;
        old_out = e_out;
        p_out[1*NL +: NL] = 16'h0000;
        #1;
        check_vec("R3", "pad_out before edge", pad_out, old_out);
        check_vec("R3", "pad_oe before edge", pad_oe, old_oe);
        settle();
        check_all("R3");

        // R5: non-selected slots toggle without effect
        p_out[2*NL +: NL] = '1;
        p_oe[2*NL +: NL]  = '1;
        p_out[6*NL +: NL] = '1;
        p_oe[6*NL +: NL]  = '1;
        settle();
        check_all("R5");

        // R6: input return, independent of selector
        pad_in = rnd128();
        settle();
        check_all("R6");
        cfg_write(5'd16, 8'd4);
        settle();
        check_all("R6");
        cfg_write(5'd16, 8'd1);

        // R8: two logical pins on one pad, lower wins even when not enabled
        map(2, 40);
        map(9, 40);
        p_oe[1*NL +: NL]  = 16'h0200;
        p_out[1*NL +: NL] = 16'h0200;
        settle();
        check_all("R8");
        check_vec("R8", "pad40 oe", {127'd0, pad_oe[40]}, '0);
        p_oe[1*NL +: NL]  = 16'h0204;
        p_out[1*NL +: NL] = 16'h0200;
        settle();
        check_all("R8");

        // R2, R7: unmapping via valid 0
        p_oe[1*NL +: NL] = '1;
        p_out[1*NL +: NL] = '1;
        cfg_write(5'd3, 8'h7f);
        settle();
        check_all("R7");

        // R4: codes with no peripheral keep all pads off
        for (int c = 0; c < 8; c++) begin
            p_out = rnd128();
            p_oe  = rnd128();
            cfg_write(5'd16, 8'(c));
            settle();
            check_all("R4");
        end

        // R12: unused addresses are ignored
        cfg_write(5'd16, 8'd5);
        for (int a = 18; a < 32; a++) cfg_write(5'(a), 8'hff);
        settle();
        check_all("R12");

        // R11: peripheral reset pulse, map kept, selector cleared
        cfg_write(5'd17, 8'h02);
        check_vec("R11", "periph_rst high", {127'd0, prst}, 128'd1);
        settle();
        check_vec("R11", "periph_rst low", {127'd0, prst}, '0);
        check_all("R11");
        cfg_write(5'd16, 8'd5);
        settle();
        check_all("R11");

        // R10: map clear keeps selector
        cfg_write(5'd17, 8'h01);
        settle();
        check_all("R10");
        map(1, 99);
        settle();
        check_all("R10");

        // Random configurations against the model
        for (int it = 0; it < 300; it++) begin
            for (int l = 0; l < NL; l++) begin
                if ($urandom % 3 != 0)
                    cfg_write(5'(l), {($urandom % 4) != 0 ? 1'b1 : 1'b0, 7'($urandom)});
            end
            cfg_write(5'd16, 8'($urandom % 8));
            p_out  = rnd128();
            p_oe   = rnd128();
            pad_in = rnd128();
            settle();
            check_all("R3");
        end

        // R1: full reset mid-run tristates everything
        rst_n = 1'b0;
        model_clear();
        #1;
        check_vec("R1", "pad_oe after reset", pad_oe, '0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check_all("R1");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule